// File: doc/BRIEF.md
# DMA Request Line Allocator

This block hands a small set of DMA request lines to USB endpoints and records who owns each line in one 32-bit mapping word. Each line has a 5-bit slot in that word. The low four bits of a slot hold the owning endpoint number, and the fifth bit marks a transmit endpoint. A slot whose endpoint field reads zero is free. Endpoint 0 never owns a line, so the zero value can mean "free".

Two operating modes are selected by a level input. In multi-line mode, five lines are handed out independently. An allocation takes the lowest free slot, and a release clears only the slot its endpoint owns. In shared mode, every endpoint goes through line 0, one at a time. Line 0 can be taken only when the whole word is zero, and it can be given back only by the endpoint that holds it. A direct write port lets software load the whole word. All responses come out as registered single-cycle pulses. The mapping word is always visible on an output.

Top module: `dma_line_alloc`

## Requirements
- R1: Synchronous reset clears the mapping word to zero. While reset is held, grant, retry and rel_err are low.
- R2: Slot i occupies bits [5i+4:5i], for i = 0 to 4. The endpoint number is in bits [5i+3:5i], and bit 5i+4 is 1 for a transmit endpoint. Allocation and release never alter bits 25 to 31.
- R3: In multi-line mode (mode_multi=1), an allocation writes {alloc_tx, alloc_ep} into the lowest slot whose endpoint field is zero. One cycle after the request, grant pulses with grant_line set to that slot index.
- R4: An allocation that finds no usable line pulses retry one cycle later, does not pulse grant, and leaves the mapping word unchanged.
- R5: In multi-line mode, a release clears all five bits of the lowest slot whose endpoint field equals rel_ep and leaves the other slots unchanged. If no slot matches, rel_err pulses and the word is unchanged.
- R6: In shared mode (mode_multi=0), an allocation fails with retry if any bit of the 32-bit word is set. Otherwise the word becomes {alloc_tx, alloc_ep} in bits [4:0] with all other bits zero, and grant pulses with grant_line = 0.
- R7: In shared mode, a release clears the whole word when bits [3:0] equal rel_ep. Otherwise rel_err pulses and the word is unchanged.
- R8: An allocation for endpoint 0 always gets retry. A release for endpoint 0 always gets rel_err and changes nothing.
- R9: When a release and an allocation arrive in the same cycle, the release is applied first, and the allocation sees the line it freed.
- R10: wr_en loads wr_data into the word on the next edge. An allocation or release in that same cycle is ignored and produces no pulse.
- R11: grant, retry and rel_err are single-cycle pulses. They stay low in any cycle that follows one with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_multi | input | 1 | 1 = independent lines, 0 = shared line 0 |
| alloc_req | input | 1 | Allocation request strobe |
| alloc_ep | input | 4 | Endpoint asking for a line |
| alloc_tx | input | 1 | Requesting endpoint transmits |
| rel_req | input | 1 | Release request strobe |
| rel_ep | input | 4 | Endpoint giving its line back |
| wr_en | input | 1 | Direct load of the mapping word |
| wr_data | input | 32 | Value for the direct load |
| grant | output | 1 | Allocation succeeded (pulse) |
| grant_line | output | 3 | Index of the granted line |
| retry | output | 1 | Allocation refused, try later (pulse) |
| rel_err | output | 1 | Release refused (pulse) |
| map_out | output | 32 | Current mapping word |

## Verification
Every piece of internal state is the mapping word itself, and that word is on map_out. A wrong slot write, a stray clear or a damaged upper bit therefore shows up one clock after the request that caused it. A fault in the free-slot or owner search shows up in the same cycle as the wrong value on grant_line, a missing grant, or an unwarranted retry or rel_err. A reference model runs alongside the design and compares all five outputs after every edge, so no fault can stay hidden behind later traffic.

// File: rtl/dla_pkg.sv
`timescale 1ns/1ps
package dla_pkg;
  localparam int EP_W_DEF      = 4;
  localparam int NUM_LINES_DEF = 5;
  localparam int MAP_W_DEF     = 32;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dla_slot_match.sv
`timescale 1ns/1ps
// Compares every slot's endpoint field against one key.
module dla_slot_match #(
  parameter int EP_W      = 4,
  parameter int NUM_LINES = 5
) (
  input  logic [NUM_LINES*EP_W-1:0] fields,
  input  logic [EP_W-1:0]           key,
  output logic [NUM_LINES-1:0]      hits
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_cmp
    assign hits[g] = (fields[g*EP_W +: EP_W] == key);
  end
endmodule

// File: rtl/dla_prio_enc.sv
`timescale 1ns/1ps
// Lowest-index-wins priority encoder.
module dla_prio_enc #(
  parameter int N     = 5,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dma_line_alloc.sv
`timescale 1ns/1ps
module dma_line_alloc #(
  parameter int EP_W      = dla_pkg::EP_W_DEF,
  parameter int NUM_LINES = dla_pkg::NUM_LINES_DEF,
  parameter int MAP_W     = dla_pkg::MAP_W_DEF,
  parameter int LINE_W    = dla_pkg::idx_width(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_multi,
  input  logic              alloc_req,
  input  logic [EP_W-1:0]   alloc_ep,
  input  logic              alloc_tx,
  input  logic              rel_req,
  input  logic [EP_W-1:0]   rel_ep,
  input  logic              wr_en,
  input  logic [MAP_W-1:0]  wr_data,
  output logic              grant,
  output logic [LINE_W-1:0] grant_line,
  output logic              retry,
  output logic              rel_err,
  output logic [MAP_W-1:0]  map_out
);
  localparam int SLOT_W = EP_W + 1;
  localparam int USED_W = NUM_LINES * SLOT_W;

  initial begin
    if (USED_W > MAP_W) $error("slots do not fit the mapping word");
  end

  logic [MAP_W-1:0] map_q, map_rel, map_nxt;
  logic [MAP_W-1:0] own_mask, free_mask, entry_shift;
  logic [SLOT_W-1:0] entry;
  logic [NUM_LINES*EP_W-1:0] cur_fields, rel_fields;
  logic [NUM_LINES-1:0] own_hits, free_hits;
  logic own_found, free_found;
  logic [LINE_W-1:0] own_idx, free_idx, give_line;
  logic rel_bad, give, deny;

  // Endpoint fields before and after the release stage
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_fields
    assign cur_fields[g*EP_W +: EP_W] = map_q[g*SLOT_W +: EP_W];
    assign rel_fields[g*EP_W +: EP_W] = map_rel[g*SLOT_W +: EP_W];
  end

  dla_slot_match #(.EP_W(EP_W), .NUM_LINES(NUM_LINES)) i_own_match (
    .fields(cur_fields), .key(rel_ep), .hits(own_hits));
  dla_prio_enc #(.N(NUM_LINES), .IDX_W(LINE_W)) i_own_enc (
    .vec(own_hits), .found(own_found), .idx(own_idx));

  dla_slot_match #(.EP_W(EP_W), .NUM_LINES(NUM_LINES)) i_free_match (
    .fields(rel_fields), .key({EP_W{1'b0}}), .hits(free_hits));
  dla_prio_enc #(.N(NUM_LINES), .IDX_W(LINE_W)) i_free_enc (
    .vec(free_hits), .found(free_found), .idx(free_idx));

  assign entry       = {alloc_tx, alloc_ep};
  assign own_mask    = MAP_W'({SLOT_W{1'b1}}) << (int'(own_idx) * SLOT_W);
  assign free_mask   = MAP_W'({SLOT_W{1'b1}}) << (int'(free_idx) * SLOT_W);
  assign entry_shift = MAP_W'(entry) << (int'(free_idx) * SLOT_W);

  // Release stage first, allocation sees its result
  always_comb begin
    map_rel = map_q;
    rel_bad = 1'b0;
    if (rel_req) begin
      if (rel_ep == '0) begin
        rel_bad = 1'b1;
      end else if (mode_multi) begin
        if (own_found) map_rel = map_q & ~own_mask;
        else           rel_bad = 1'b1;
      end else if (map_q[EP_W-1:0] == rel_ep) begin
        map_rel = '0;
      end else begin
        rel_bad = 1'b1;
      end
    end

    map_nxt   = map_rel;
    give      = 1'b0;
    deny      = 1'b0;
    give_line = '0;
    if (alloc_req) begin
      if (alloc_ep == '0) begin
        deny = 1'b1;
      end else if (mode_multi) begin
        if (free_found) begin
          map_nxt   = (map_rel & ~free_mask) | entry_shift;
          give      = 1'b1;
          give_line = free_idx;
        end else begin
          deny = 1'b1;
        end
      end else if (map_rel != '0) begin
        deny = 1'b1;
      end else begin
        map_nxt = MAP_W'(entry);
        give    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q      <= '0;
      grant      <= 1'b0;
      grant_line <= '0;
      retry      <= 1'b0;
      rel_err    <= 1'b0;
    end else if (wr_en) begin
      map_q      <= wr_data;
      grant      <= 1'b0;
      grant_line <= '0;
      retry      <= 1'b0;
      rel_err    <= 1'b0;
    end else begin
      map_q      <= map_nxt;
      grant      <= give;
      grant_line <= give_line;
      retry      <= deny;
      rel_err    <= rel_bad;
    end
  end

  assign map_out = map_q;

  // R3 / R4: a request gets at most one kind of answer
  p_one_answer_r4: assert property (@(posedge clk) disable iff (rst)
    !(grant && retry));

  // R4: a refused lone allocation leaves the word alone
  p_retry_keeps_map_r4: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && !rel_req && !wr_en) |=> (!retry || map_out == $past(map_out)));

  // R6: the shared mode only ever grants line 0 and fills only the low slot
  p_shared_line0_r6: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && !mode_multi && !wr_en) |=>
      (!grant || (grant_line == '0 && map_out[MAP_W-1:SLOT_W] == '0)));

  // R8: endpoint 0 is refused on both paths
  p_ep0_alloc_r8: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && alloc_ep == '0 && !wr_en) |=> (retry && !grant));
  p_ep0_rel_r8: assert property (@(posedge clk) disable iff (rst)
    (rel_req && rel_ep == '0 && !wr_en) |=> rel_err);

  // R10: direct load wins and silences the responses
  p_direct_load_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (map_out == $past(wr_data) && !grant && !retry && !rel_err));

  // R11: no request, no pulse
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (!alloc_req && !rel_req) |=> (!grant && !retry && !rel_err));
endmodule

// File: tb/test_dma_line_alloc.sv
`timescale 1ns/1ps
module test_dma_line_alloc;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_multi = 1'b0, alloc_req = 1'b0, alloc_tx = 1'b0, rel_req = 1'b0, wr_en = 1'b0;
  logic [3:0] alloc_ep = '0, rel_ep = '0;
  logic [31:0] wr_data = '0;
  logic grant, retry, rel_err;
  logic [2:0] grant_line;
  logic [31:0] map_out;

  always #2 clk = ~clk;  // 250 MHz

  dma_line_alloc i_dma_line_alloc (
    .clk(clk), .rst(rst), .mode_multi(mode_multi),
    .alloc_req(alloc_req), .alloc_ep(alloc_ep), .alloc_tx(alloc_tx),
    .rel_req(rel_req), .rel_ep(rel_ep), .wr_en(wr_en), .wr_data(wr_data),
    .grant(grant), .grant_line(grant_line), .retry(retry), .rel_err(rel_err),
    .map_out(map_out));

  typedef struct {
    logic g; logic [2:0] ln; logic r; logic e; logic [31:0] m; string tag;
  } exp_t;

  exp_t q[$];
  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] m_map = '0;

  task automatic report(input string tag, input exp_t e);
    n_bad++;
    $display("FAIL %s: got grant=%0b line=%0d retry=%0b err=%0b map=%h, expected grant=%0b line=%0d retry=%0b err=%0b map=%h",
             tag, grant, grant_line, retry, rel_err, map_out, e.g, e.ln, e.r, e.e, e.m);
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected answer
  task automatic apply(input logic mm, input logic ar, input logic [3:0] aep, input logic atx,
                       input logic rr, input logic [3:0] rep, input logic we,
                       input logic [31:0] wd, input string tag);
    exp_t e;
    logic [31:0] nm;
    logic hit;
    @(negedge clk);
    mode_multi = mm; alloc_req = ar; alloc_ep = aep; alloc_tx = atx;
    rel_req = rr; rel_ep = rep; wr_en = we; wr_data = wd;
    e.g = 0; e.ln = 0; e.r = 0; e.e = 0; e.tag = tag;
    nm = m_map;
    if (we) nm = wd;
    else begin
      if (rr) begin
        if (rep == 0) e.e = 1;
        else if (mm) begin
          hit = 0;
          for (int i = 0; i < 5; i++)
            if (!hit && nm[5*i +: 4] == rep) begin nm[5*i +: 5] = '0; hit = 1; end
          if (!hit) e.e = 1;
        end else if (nm[3:0] == rep) nm = '0;
        else e.e = 1;
      end
      if (ar) begin
        if (aep == 0) e.r = 1;
        else if (mm) begin
          hit = 0;
          for (int i = 0; i < 5; i++)
            if (!hit && nm[5*i +: 4] == 4'd0) begin
              nm[5*i +: 5] = {atx, aep}; hit = 1; e.g = 1; e.ln = 3'(i);
            end
          if (!hit) e.r = 1;
        end else if (nm != 0) e.r = 1;
        else begin nm = {27'd0, atx, aep}; e.g = 1; end
      end
    end
    e.m = nm;
    m_map = nm;
    q.push_back(e);
  endtask

  // Monitor: compares after each edge
  always @(posedge clk) begin
    #1;
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (grant !== e.g || retry !== e.r || rel_err !== e.e || map_out !== e.m ||
          (e.g && grant_line !== e.ln))
        report(e.tag, e);
    end
  end

  initial begin
    #80000;
    n_bad++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++;  // R1 reset state
    if (map_out !== 32'd0 || grant !== 1'b0 || retry !== 1'b0 || rel_err !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got map=%h grant=%0b retry=%0b err=%0b, expected all zero",
               map_out, grant, retry, rel_err);
    end
    rst = 1'b0;

    // Multi-line mode filling
    apply(1, 1, 4'd3, 1, 0, 0, 0, 0, "R3 first alloc, R2 tx bit");
    apply(1, 1, 4'd5, 0, 0, 0, 0, 0, "R3 second slot");
    apply(1, 1, 4'd1, 1, 0, 0, 0, 0, "R3 third slot");
    apply(1, 1, 4'd2, 0, 0, 0, 0, 0, "R3 fourth slot");
    apply(1, 1, 4'd7, 1, 0, 0, 0, 0, "R3 fifth slot R2 layout");
    apply(1, 1, 4'd9, 0, 0, 0, 0, 0, "R4 all lines owned");
    apply(1, 0, 0, 0, 0, 0, 0, 0, "R11 idle");
    apply(1, 0, 0, 0, 1, 4'd5, 0, 0, "R5 release middle slot");
    apply(1, 0, 0, 0, 1, 4'd12, 0, 0, "R5 unknown owner");
    apply(1, 1, 4'd6, 0, 0, 0, 0, 0, "R3 reuse lowest hole");
    apply(1, 1, 4'd8, 1, 1, 4'd3, 0, 0, "R9 release then alloc same cycle");
    apply(1, 1, 4'd0, 1, 0, 0, 0, 0, "R8 ep0 alloc");
    apply(1, 0, 0, 0, 1, 4'd0, 0, 0, "R8 ep0 release");
    apply(1, 0, 0, 0, 1, 4'd7, 0, 0, "R5 release top slot");
    apply(1, 0, 0, 0, 0, 0, 0, 0, "R11 idle after error");
    // Direct load and free-by-endpoint-field
    apply(1, 1, 4'd4, 0, 1, 4'd1, 1, 32'h0000_0010, "R10 load overrides requests");
    apply(1, 1, 4'd4, 0, 0, 0, 0, 0, "R3 slot with only tx bit is free");
    apply(1, 0, 0, 0, 0, 0, 1, 32'h0200_0000, "R10 load upper bit");
    apply(1, 1, 4'd1, 0, 0, 0, 0, 0, "R2 upper bits untouched by alloc");
    apply(1, 0, 0, 0, 1, 4'd1, 0, 0, "R2 upper bits untouched by release");
    // Shared mode
    apply(0, 1, 4'd2, 1, 0, 0, 0, 0, "R6 any set bit blocks line 0");
    apply(0, 0, 0, 0, 0, 0, 1, 32'd0, "R10 clear word");
    apply(0, 1, 4'd2, 1, 0, 0, 0, 0, "R6 shared grant");
    apply(0, 1, 4'd3, 0, 0, 0, 0, 0, "R6 shared busy");
    apply(0, 0, 0, 0, 1, 4'd3, 0, 0, "R7 wrong owner release");
    apply(0, 1, 4'd3, 0, 1, 4'd2, 0, 0, "R9 shared release then alloc");
    apply(0, 0, 0, 0, 1, 4'd3, 0, 0, "R7 owner release");
    apply(0, 1, 4'd0, 0, 0, 0, 0, 0, "R8 ep0 shared alloc");
    apply(0, 0, 0, 0, 0, 0, 0, 0, "R11 idle end");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule